// File: doc/BRIEF.md
# Single-Wire Pulse Token Transceiver

This block is the physical layer of a half-duplex, open-drain single-wire link on which each bit is a short burst of timed low pulses rather than a level. While the link is asleep it watches for a long low (the wake token). After that token it waits out a fixed settling interval and then turns each incoming token into a received bit. A token made of a lone start pulse carries a one. A token in which the start pulse is followed by a short high and a second short low carries a zero. In the other direction it sends response bits by pulling the line low with the same pulse pattern. It never drives the line high.

The link drops back to sleep in three cases: the local sleep input asks for it, no legal token arrives within the inactivity timeout, or a malformed token is seen and the timeout then runs out. Two input filters remove glitches: a short one while awake and a longer one while asleep. Every duration is a parameter counted in ticks of the `tick` clock enable. Byte assembly, flags, checksums and command handling belong to the layers above.

The controller is one state machine. `SLEEP`: waiting for any filtered low. `WAKE_LOW`: measuring that low. `WAKE_WAIT`: the settling delay after a valid wake, during which the line is ignored. `IDLE`: armed, waiting for a start edge or a transmit request. `RX_WIN`: counting falling edges inside the decode window. `BAD`: a malformed token was seen, so the machine waits for the timeout. `TX`: sending one bit. The transitions are named as follows.
- *sleep-req*: any state goes to `SLEEP`.
- *low-seen*: `SLEEP` goes to `WAKE_LOW`.
- *too-short*: `WAKE_LOW` goes back to `SLEEP`.
- *woken*: `WAKE_LOW` goes to `WAKE_WAIT`.
- *settled*: `WAKE_WAIT` goes to `IDLE`.
- *start-edge*: `IDLE` goes to `RX_WIN`.
- *tx-accept*: `IDLE` goes to `TX`.
- *window-end*: `RX_WIN` goes to `IDLE`.
- *malformed*: `RX_WIN` goes to `BAD`.
- *bit-sent*: `TX` goes to `IDLE`.
- *expired*: `IDLE`, `RX_WIN` or `BAD` goes to `SLEEP`.

Top module: `pulse_token_phy`

## Requirements
- R1: After reset the link is asleep (`link_awake`=0), `pull_low` is 0 and no strobe is raised.
- R2: While asleep, a filtered low lasting at least WAKE_LOW ticks that then returns high raises `wake_pulse` for one cycle and sets `link_awake`. A low that is shorter returns to sleep without a wake.
- R3: Lows shorter than GLITCH_SLP ticks are ignored while asleep. Lows shorter than GLITCH_ACT ticks are ignored while awake and produce no received bit.
- R4: For WAKE_DELAY ticks after a wake, activity on the line is ignored and produces no received bit.
- R5: In IDLE, a falling edge opens a window of RX_WINDOW ticks. Exactly one falling edge in the window gives `rx_bit`=1. Exactly two give `rx_bit`=0. Either way `rx_valid` pulses once, at the end of the window.
- R6: A token whose low lasts more than ZERO_LOW_MAX ticks, or that has three or more falling edges in the window, yields no bit. The link then sleeps when the timeout expires.
- R7: An awake link that sees no received bit and completes no transmit for TIMEOUT ticks goes to sleep. Each received bit and each completed transmit restarts the count.
- R8: `tx_req` in IDLE sends `tx_bit`. A one is a single low of TX_PULSE ticks. A zero adds a second low of TX_PULSE ticks that starts at tick 2*TX_PULSE. `tx_ack` pulses in the cycle the TX_PERIOD-tick bit ends, and `pull_low` is 0 at that point.
- R9: While asleep, `tx_req` is ignored and `pull_low` stays 0.
- R10: `sleep_req` puts the link to sleep on the next cycle, aborts a transmit in progress without `tx_ack`, and releases the line.
- R11: While `tick` is 0 no timer, filter or pulse advances. The link neither times out nor raises a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable that defines the duration unit |
| line_in | input | 1 | Sampled level of the shared line |
| pull_low | output | 1 | 1 pulls the line low; 0 releases it |
| rx_bit | output | 1 | Decoded bit value, valid with `rx_valid` |
| rx_valid | output | 1 | One-cycle strobe for a received bit |
| wake_pulse | output | 1 | One-cycle strobe on a valid wake token |
| tx_bit | input | 1 | Bit to send |
| tx_req | input | 1 | Request to send `tx_bit`; hold until `tx_ack` |
| tx_ack | output | 1 | One-cycle strobe when the bit has been sent |
| sleep_req | input | 1 | Forces the link to sleep |
| link_awake | output | 1 | 1 while the link is out of sleep |

## Verification
The checker assumes that `tick` is the only thing that paces the timers. It also assumes that `sleep_req` is a plain level which may arrive in any state, including the middle of a transmit. The properties therefore check strobe exclusivity, line release and the freeze under `tick`=0 without assuming anything about line activity. The stimulus drives the line as a wired-AND of the host's pull and the block's own `pull_low`, so the block hears its own transmit the way a real bus would return it. Host pulses are always longer than the active filter, except where a glitch is the point of the test. Host bit periods are longer than the decode window, and tokens are spaced well inside the timeout unless expiry is being tested.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_WAKE_LOW,
        ST_WAKE_WAIT,
        ST_IDLE,
        ST_RX_WIN,
        ST_BAD,
        ST_TX
    } pt_state_e;

endpackage

// File: rtl/pt_deglitch.sv
// Accepts a new line level only after it has differed from the current
// filtered level for len consecutive ticks.
module pt_deglitch #(
    parameter int MAX_LEN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         raw,
    input  logic [$clog2(MAX_LEN+1)-1:0] len,
    output logic                         filt
);
    localparam int LW = $clog2(MAX_LEN + 1);

    logic [LW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt  <= 1'b1;
            run_q <= '0;
        end else if (tick) begin
            if (raw == filt) begin
                run_q <= '0;
            end else if (LW'(run_q + 1'b1) >= len) begin
                filt  <= raw;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pt_timeout.sv
// Saturating inactivity counter; expired stays high until cleared.
module pt_timeout #(
    parameter int LIMIT = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic en,
    input  logic clr,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (tick && en && (cnt_q != TW'(LIMIT))) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == TW'(LIMIT));

endmodule

// File: rtl/pt_tx.sv
// Generates one outgoing token; only ever asks for the line to be pulled low.
module pt_tx #(
    parameter int PULSE  = 3,
    parameter int PERIOD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic bit_in,
    input  logic abort,
    output logic pull,
    output logic done
);
    localparam int CW = $clog2(PERIOD);

    logic          busy_q;
    logic          bit_q;
    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(PERIOD - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            bit_q  <= 1'b1;
            cnt_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            bit_q  <= bit_in;
            cnt_q  <= '0;
        end else if (busy_q && tick) begin
            if (last) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pull = busy_q && ((cnt_q < CW'(PULSE)) ||
                  (!bit_q && (cnt_q >= CW'(2 * PULSE)) && (cnt_q < CW'(3 * PULSE))));
    assign done = busy_q && tick && !abort && last;

endmodule

// File: rtl/pulse_token_phy.sv
module pulse_token_phy #(
    parameter int GLITCH_ACT   = 2,
    parameter int GLITCH_SLP   = 4,
    parameter int WAKE_LOW     = 8,
    parameter int WAKE_DELAY   = 20,
    parameter int RX_WINDOW    = 16,
    parameter int ZERO_LOW_MAX = 6,
    parameter int TIMEOUT      = 60,
    parameter int TX_PULSE     = 3,
    parameter int TX_PERIOD    = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic line_in,
    output logic pull_low,
    output logic rx_bit,
    output logic rx_valid,
    output logic wake_pulse,
    input  logic tx_bit,
    input  logic tx_req,
    output logic tx_ack,
    input  logic sleep_req,
    output logic link_awake
);
    import pt_pkg::*;

    localparam int GMAX  = (GLITCH_SLP > GLITCH_ACT) ? GLITCH_SLP : GLITCH_ACT;
    localparam int GW    = $clog2(GMAX + 1);
    localparam int PMAX0 = (WAKE_LOW > WAKE_DELAY) ? WAKE_LOW : WAKE_DELAY;
    localparam int PMAX  = (PMAX0 > RX_WINDOW) ? PMAX0 : RX_WINDOW;
    localparam int PCW   = $clog2(PMAX + 1);
    localparam int LRMAX = ZERO_LOW_MAX + 1;
    localparam int LRW   = $clog2(LRMAX + 1);

    pt_state_e      state_q, state_d;
    logic [PCW-1:0] cnt_q, cnt_d;
    logic [LRW-1:0] low_q, low_d, low_nx;
    logic [1:0]     edge_q, edge_d, edge_nx;
    logic           filt, filt_prev, fall;
    logic           expired, timer_en, timer_clr;
    logic           tx_start, tx_done, tx_pull;
    logic           asleep, malformed, win_end, wake_ok;
    logic [GW-1:0]  flt_len;

    assign asleep  = (state_q == ST_SLEEP) || (state_q == ST_WAKE_LOW);
    assign flt_len = asleep ? GW'(GLITCH_SLP) : GW'(GLITCH_ACT);

    pt_deglitch #(.MAX_LEN(GMAX)) u_flt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(line_in),
        .len(flt_len), .filt(filt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    filt_prev <= 1'b1;
        else if (tick) filt_prev <= filt;
    end
    assign fall = filt_prev && !filt;

    assign low_nx    = filt ? '0 : ((low_q == LRW'(LRMAX)) ? low_q : low_q + 1'b1);
    assign edge_nx   = (edge_q == 2'd3) ? edge_q : edge_q + {1'b0, fall};
    assign malformed = (low_nx > LRW'(ZERO_LOW_MAX)) || (edge_nx > 2'd2);
    assign win_end   = (cnt_q == PCW'(RX_WINDOW - 1));
    assign wake_ok   = (cnt_q >= PCW'(WAKE_LOW));

    assign timer_en  = (state_q == ST_IDLE) || (state_q == ST_RX_WIN) || (state_q == ST_BAD);
    assign timer_clr = rx_valid || tx_done || asleep || (state_q == ST_WAKE_WAIT);

    pt_timeout #(.LIMIT(TIMEOUT)) u_tmo (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(timer_en),
        .clr(timer_clr), .expired(expired)
    );

    pt_tx #(.PULSE(TX_PULSE), .PERIOD(TX_PERIOD)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_start),
        .bit_in(tx_bit), .abort(sleep_req), .pull(tx_pull), .done(tx_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SLEEP;
            cnt_q   <= '0;
            low_q   <= '0;
            edge_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            low_q   <= low_d;
            edge_q  <= edge_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        low_d   = low_q;
        edge_d  = edge_q;
        if (sleep_req) begin
            state_d = ST_SLEEP;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_SLEEP: begin
                    if (!filt) begin
                        state_d = ST_WAKE_LOW;
                        cnt_d   = PCW'(1);
                    end
                end
                ST_WAKE_LOW: begin
                    if (filt) begin
                        state_d = wake_ok ? ST_WAKE_WAIT : ST_SLEEP;
                        cnt_d   = '0;
                    end else if (!wake_ok) begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_WAKE_WAIT: begin
                    if (cnt_q == PCW'(WAKE_DELAY - 1)) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (expired) begin
                        state_d = ST_SLEEP;
                    end else if (fall) begin
                        state_d = ST_RX_WIN;
                        cnt_d   = '0;
                        low_d   = LRW'(1);
                        edge_d  = 2'd1;
                    end else if (tx_req) begin
                        state_d = ST_TX;
                    end
                end
                ST_RX_WIN: begin
                    low_d  = low_nx;
                    edge_d = edge_nx;
                    cnt_d  = cnt_q + 1'b1;
                    if (expired)        state_d = ST_SLEEP;
                    else if (malformed) state_d = ST_BAD;
                    else if (win_end)   state_d = ST_IDLE;
                end
                ST_BAD: begin
                    if (expired) state_d = ST_SLEEP;
                end
                ST_TX: begin
                    if (tx_done) state_d = ST_IDLE;
                end
                default: state_d = ST_SLEEP;
            endcase
        end
    end

    // outputs
    always_comb begin
        rx_valid   = 1'b0;
        wake_pulse = 1'b0;
        tx_start   = 1'b0;
        if (tick && !sleep_req) begin
            unique case (state_q)
                ST_WAKE_LOW: wake_pulse = filt && wake_ok;
                ST_IDLE:     tx_start   = !expired && !fall && tx_req;
                ST_RX_WIN:   rx_valid   = !expired && !malformed && win_end;
                default:     ;
            endcase
        end
        rx_bit     = (edge_nx == 2'd1);
        tx_ack     = tx_done;
        pull_low   = tx_pull;
        link_awake = !asleep;
    end

endmodule

// File: rtl/pulse_token_phy_checker.sv
module pulse_token_phy_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic sleep_req,
    input logic link_awake,
    input logic pull_low,
    input logic rx_valid,
    input logic wake_pulse,
    input logic tx_ack
);
    assert_wake_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> link_awake && !wake_pulse);

    assert_rx_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> link_awake && !wake_pulse && !pull_low);

    assert_rx_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ack |-> !pull_low && link_awake);

    assert_no_pull_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !link_awake |-> !pull_low);

    assert_sleep_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !link_awake && !pull_low && !tx_ack);

    assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !sleep_req) |=> $stable(link_awake) && $stable(pull_low));

    assert_no_strobe_idle_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |-> !rx_valid && !wake_pulse && !tx_ack);
endmodule

bind pulse_token_phy pulse_token_phy_checker u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_req(sleep_req),
    .link_awake(link_awake), .pull_low(pull_low), .rx_valid(rx_valid),
    .wake_pulse(wake_pulse), .tx_ack(tx_ack)
);

// File: tb/pulse_token_phy_test.sv
module pulse_token_phy_test;
    localparam int P_HOST = 4;
    localparam int T_HOST = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic host_low = 1'b0;
    logic tx_bit = 1'b0, tx_req = 1'b0, sleep_req = 1'b0;
    logic pull_low, rx_bit, rx_valid, wake_pulse, tx_ack, link_awake;
    wire  line_in = !(host_low || pull_low);

    int checks = 0, errors = 0;
    int rx_cnt = 0, wake_cnt = 0, pulse_cnt = 0, pull_cyc = 0, ack_cnt = 0;
    logic last_bit = 1'b0, prev_pull = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    pulse_token_phy uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .line_in(line_in),
        .pull_low(pull_low), .rx_bit(rx_bit), .rx_valid(rx_valid),
        .wake_pulse(wake_pulse), .tx_bit(tx_bit), .tx_req(tx_req),
        .tx_ack(tx_ack), .sleep_req(sleep_req), .link_awake(link_awake)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin rx_cnt++; last_bit = rx_bit; end
            if (wake_pulse) wake_cnt++;
            if (tx_ack) ack_cnt++;
            if (pull_low && !prev_pull) pulse_cnt++;
            if (pull_low) pull_cyc++;
        end
        prev_pull = pull_low;
    end

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic low(int n);
        host_low = 1'b1; cyc(n); host_low = 1'b0;
    endtask

    task automatic send_bit(logic b);
        low(P_HOST); cyc(P_HOST);
        if (!b) begin low(P_HOST); cyc(T_HOST - 3 * P_HOST); end
        else cyc(T_HOST - 2 * P_HOST);
    endtask

    task automatic wake();
        low(14); cyc(30);
    endtask

    task automatic go_sleep();
        sleep_req = 1'b1; cyc(1); sleep_req = 1'b0;
    endtask

    task automatic do_tx(logic b);
        int n, p0, c0;
        p0 = pulse_cnt; c0 = pull_cyc; n = 0;
        tx_bit = b; tx_req = 1'b1;
        while (n < 100) begin
            cyc(1); n++;
            if (tx_ack) break;
        end
        tx_req = 1'b0;
        cyc(2);
        check_eq("R8 ack cycles", n, 20);
        check_eq("R8 pulse count", pulse_cnt - p0, b ? 1 : 2);
        check_eq("R8 low cycles", pull_cyc - c0, b ? 3 : 6);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r0;
        cyc(5);
        // R1 reset state
        check_eq("R1 awake", int'(link_awake), 0);
        check_eq("R1 pull", int'(pull_low), 0);
        rst_n = 1'b1;
        cyc(5);
        check_eq("R1 strobes", rx_cnt + wake_cnt + ack_cnt, 0);

        // R3 sleep glitch, R2 too-short wake, then valid wake
        low(3); cyc(20);
        check_eq("R3 sleep glitch", wake_cnt, 0);
        low(6); cyc(20);
        check_eq("R2 short low", wake_cnt, 0);
        check_eq("R2 short awake", int'(link_awake), 0);
        // R4: pulse during the wake delay
        r0 = rx_cnt;
        low(14); cyc(6); low(4); cyc(20);
        check_eq("R2 wake count", wake_cnt, 1);
        check_eq("R2 awake", int'(link_awake), 1);
        check_eq("R4 ignored during delay", rx_cnt - r0, 0);

        // R5 sweep of all 4-bit patterns, LSB first
        for (int p = 0; p < 16; p++) begin
            int got;
            got = 0; r0 = rx_cnt;
            for (int i = 0; i < 4; i++) begin
                send_bit(p[i]);
                got |= int'(last_bit) << i;
            end
            check_eq("R5 bit count", rx_cnt - r0, 4);
            check_eq("R5 pattern", got, p);
        end

        // R3 active glitch
        r0 = rx_cnt;
        low(1); cyc(31);
        check_eq("R3 active glitch", rx_cnt - r0, 0);
        check_eq("R7 awake after tokens", int'(link_awake), 1);

        // R8 transmit sweep
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < 2; i++) do_tx(v[i]);
        end

        // R7 timeout after last transmit
        cyc(38);
        check_eq("R7 before timeout", int'(link_awake), 1);
        cyc(40);
        check_eq("R7 after timeout", int'(link_awake), 0);

        // R11 freeze with tick low
        wake();
        tick = 1'b0; cyc(200); tick = 1'b1;
        check_eq("R11 still awake", int'(link_awake), 1);
        r0 = rx_cnt;
        send_bit(1'b0);
        check_eq("R11 bit after freeze", rx_cnt - r0, 1);
        check_eq("R11 bit value", int'(last_bit), 0);
        go_sleep();

        // R6 / R3 / R5 low-length sweep
        for (int len = 1; len <= 9; len++) begin
            int exp_n;
            exp_n = (len < 2) ? 0 : ((len <= 6) ? 1 : 0);
            wake();
            r0 = rx_cnt;
            low(len); cyc(31);
            check_eq("R6 length sweep count", rx_cnt - r0, exp_n);
            if (exp_n == 1) check_eq("R5 single start is one", int'(last_bit), 1);
            if (len > 6) begin
                cyc(70);
                check_eq("R6 sleep after illegal", int'(link_awake), 0);
            end else begin
                go_sleep();
            end
        end

        // R6 three edges in window
        wake();
        r0 = rx_cnt;
        low(2); cyc(2); low(2); cyc(2); low(2); cyc(30);
        check_eq("R6 three edges", rx_cnt - r0, 0);
        cyc(70);
        check_eq("R6 three edges sleep", int'(link_awake), 0);

        // R9 tx request while asleep
        r0 = pulse_cnt;
        tx_bit = 1'b0; tx_req = 1'b1; cyc(40); tx_req = 1'b0;
        check_eq("R9 no pull asleep", pulse_cnt - r0, 0);

        // R10 abort transmit by sleep request
        wake();
        r0 = ack_cnt;
        tx_bit = 1'b0; tx_req = 1'b1; cyc(2);
        sleep_req = 1'b1; cyc(1); sleep_req = 1'b0; tx_req = 1'b0;
        check_eq("R10 pull released", int'(pull_low), 0);
        check_eq("R10 asleep", int'(link_awake), 0);
        cyc(30);
        check_eq("R10 no ack", ack_cnt - r0, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule